// File: doc/BRIEF.md
# Double-Buffered Frame Address Sequencer

This block produces the read address that a display pipeline uses to scan a frame buffer. Two frame buffers sit on two separate external memory buses. At any moment one of them is being displayed and the other is free for another agent to fill. The block owns the address lines of both buses. It drives the live scan address onto the displayed bus and releases the other bus to high impedance across its full width.

A slow vertical-sync input marks frame boundaries. That input is never used as a clock. It is sampled by the system clock through two registers. A falling edge seen between the two samples flips the display selection and restarts the scan from address 0. A prescaler divides the system clock so that the address advances once per pixel slot. The address counter wraps at the end of a frame even when no sync edge arrives.

Top module: `frame_addr_sequencer`

## Requirements
- R1: `rst` is a synchronous, active-high reset. After a clock edge with `rst` high, `swap_state` is 0 and `frame_start` is 0. `bus_a_oe` is 1 and `bus_a_addr` carries 0. `bus_b_oe` is 0.
- R2: While no vsync falling edge occurs, the displayed address changes exactly once every `PRESCALE` clocks (default 32), and each change is an increment by one.
- R3: After the displayed address reaches `FRAME_LEN-1` (default 19199), the next advance gives 0. The counter never holds a value of `FRAME_LEN` or above.
- R4: `vsync_in` is captured by two system-clock registers. When the older sample is 1 and the newer sample is 0, `swap_state` inverts on that clock edge. A 1-to-0 step applied before clock edge k becomes visible on `swap_state` after edge k+1.
- R5: A rising edge of `vsync_in`, or a steady level on it, never changes `swap_state`.
- R6: On the edge where `swap_state` inverts, the prescaler and the address counter both restart at 0. `frame_start` is 1 for exactly the clock cycle in which `swap_state` shows its new value.
- R7: The bus outputs are registered one clock behind the counter and the selection. The displayed bus carries the counter value of the previous cycle. It is bus A (`bus_a_oe`=1) when the previous `swap_state` was 0, and bus B (`bus_b_oe`=1) when it was 1.
- R8: The bus that is not displayed has its output enable at 0 and all `ADDR_W` bits at high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Raw vertical sync, asynchronous to `clk` |
| bus_a_addr | output | ADDR_W | Address lines of memory bus A, high impedance when released |
| bus_a_oe | output | 1 | 1 while bus A is driven |
| bus_b_addr | output | ADDR_W | Address lines of memory bus B, high impedance when released |
| bus_b_oe | output | 1 | 1 while bus B is driven |
| frame_start | output | 1 | One-cycle pulse in the cycle the display selection changes |
| swap_state | output | 1 | Current selection: 0 shows bus A, 1 shows bus B |

## Verification
The bench measures the gap between address changes. A prescaler off by one would give 31 or 33 clocks instead of 32. The bench also watches the last frame position. A counter with the wrong limit would emit `FRAME_LEN` or stall instead of returning to 0. The vsync tests hold the input high for many cycles and then release it. A detector that triggered on the wrong polarity, or on a level, would flip the selection early or keep flipping it. Every cycle the released bus is checked for a dropped output enable and for floating lines, and the driven bus is checked against a reference model. A mux that floated only one bit, or that switched without the pipeline delay, shows up there.

// File: rtl/fas_pkg.sv
package fas_pkg;

    typedef enum logic {
        SHOW_A = 1'b0,
        SHOW_B = 1'b1
    } show_e;

    typedef enum logic {
        SCAN_RUN  = 1'b0,
        SCAN_LAST = 1'b1
    } scan_e;

endpackage

// File: rtl/fas_vsync_sampler.sv
module fas_vsync_sampler (
    input  logic clk,
    input  logic rst,
    input  logic vsync_in,
    output logic fall_seen
);
    logic smp_new;
    logic smp_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_new <= 1'b0;
            smp_old <= 1'b0;
        end else begin
            smp_new <= vsync_in;
            smp_old <= smp_new;
        end
    end

    // older sample high, newer sample low: a falling edge inside the clock domain
    assign fall_seen = smp_old & ~smp_new;
endmodule

// File: rtl/fas_prescaler.sv
module fas_prescaler #(
    parameter int PRESCALE = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PHASE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (phase == PHASE_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == PHASE_LAST);
endmodule

// File: rtl/fas_addr_scan.sv
module fas_addr_scan
    import fas_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int FRAME_LEN = 19200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick,
    output logic [ADDR_W-1:0] count
);
    localparam logic [ADDR_W-1:0] POS_PENULT = ADDR_W'(FRAME_LEN - 2);

    scan_e             state;
    scan_e             state_nxt;
    logic [ADDR_W-1:0] count_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SCAN_RUN;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        count_nxt = count;
        if (restart) begin
            state_nxt = SCAN_RUN;
            count_nxt = '0;
        end else if (tick) begin
            unique case (state)
                SCAN_RUN: begin
                    count_nxt = count + 1'b1;
                    if (count == POS_PENULT) begin
                        state_nxt = SCAN_LAST;
                    end
                end
                SCAN_LAST: begin
                    count_nxt = '0;
                    state_nxt = SCAN_RUN;
                end
            endcase
        end
    end
endmodule

// File: rtl/fas_swap_ctrl.sv
module fas_swap_ctrl
    import fas_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fall_seen,
    output logic swap_state,
    output logic frame_start
);
    show_e state;
    show_e state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SHOW_A;
            frame_start <= 1'b0;
        end else begin
            state       <= state_nxt;
            frame_start <= fall_seen;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SHOW_A: if (fall_seen) state_nxt = SHOW_B;
            SHOW_B: if (fall_seen) state_nxt = SHOW_A;
        endcase
    end

    assign swap_state = (state == SHOW_B);
endmodule

// File: rtl/fas_bus_mux.sv
module fas_bus_mux #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] count,
    input  logic              swap_state,
    output logic [ADDR_W-1:0] live_addr,
    output logic              a_oe,
    output logic              b_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live_addr <= '0;
            a_oe      <= 1'b1;
            b_oe      <= 1'b0;
        end else begin
            live_addr <= count;
            a_oe      <= ~swap_state;
            b_oe      <= swap_state;
        end
    end
endmodule

// File: rtl/frame_addr_sequencer.sv
module frame_addr_sequencer #(
    parameter int ADDR_W    = 15,
    parameter int FRAME_LEN = 19200,
    parameter int PRESCALE  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync_in,
    output logic [ADDR_W-1:0] bus_a_addr,
    output logic              bus_a_oe,
    output logic [ADDR_W-1:0] bus_b_addr,
    output logic              bus_b_oe,
    output logic              frame_start,
    output logic              swap_state
);
    logic              fall_seen;
    logic              tick;
    logic [ADDR_W-1:0] scan_count;
    logic [ADDR_W-1:0] live_addr;

    fas_vsync_sampler u_sync (
        .clk      (clk),
        .rst      (rst),
        .vsync_in (vsync_in),
        .fall_seen(fall_seen)
    );

    fas_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(fall_seen),
        .tick   (tick)
    );

    fas_addr_scan #(.ADDR_W(ADDR_W), .FRAME_LEN(FRAME_LEN)) u_scan (
        .clk    (clk),
        .rst    (rst),
        .restart(fall_seen),
        .tick   (tick),
        .count  (scan_count)
    );

    fas_swap_ctrl u_swap (
        .clk        (clk),
        .rst        (rst),
        .fall_seen  (fall_seen),
        .swap_state (swap_state),
        .frame_start(frame_start)
    );

    fas_bus_mux #(.ADDR_W(ADDR_W)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .count     (scan_count),
        .swap_state(swap_state),
        .live_addr (live_addr),
        .a_oe      (bus_a_oe),
        .b_oe      (bus_b_oe)
    );

    // released bus floats on every bit, width follows ADDR_W
    assign bus_a_addr = bus_a_oe ? live_addr : {ADDR_W{1'bz}};
    assign bus_b_addr = bus_b_oe ? live_addr : {ADDR_W{1'bz}};
endmodule

// File: rtl/fas_checker.sv
module fas_checker #(
    parameter int ADDR_W    = 15,
    parameter int FRAME_LEN = 19200
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] count,
    input logic              swap_state,
    input logic              frame_start,
    input logic              bus_a_oe,
    input logic              bus_b_oe
);
    localparam logic [ADDR_W-1:0] POS_LAST = ADDR_W'(FRAME_LEN - 1);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= POS_LAST);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0)));

    p_swap_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (swap_state != $past(swap_state)) |-> frame_start);

    p_pulse_swap_r6: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (swap_state != $past(swap_state)));

    p_oe_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_a_oe == !$past(swap_state)) && (bus_b_oe == $past(swap_state)));
endmodule

bind frame_addr_sequencer fas_checker #(
    .ADDR_W   (ADDR_W),
    .FRAME_LEN(FRAME_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .count      (scan_count),
    .swap_state (swap_state),
    .frame_start(frame_start),
    .bus_a_oe   (bus_a_oe),
    .bus_b_oe   (bus_b_oe)
);

// File: tb/frame_addr_sequencer_tb.sv
module frame_addr_sequencer_tb;
    localparam int CLK_PERIOD = 20;
    localparam int AW   = 15;
    localparam int FLEN = 20;
    localparam int PRE  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vsync = 1'b0;
    logic [AW-1:0] bus_a;
    logic [AW-1:0] bus_b;
    logic          a_oe, b_oe, fs, sw;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_addr_sequencer #(.ADDR_W(AW), .FRAME_LEN(FLEN), .PRESCALE(PRE)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .vsync_in   (vsync),
        .bus_a_addr (bus_a),
        .bus_a_oe   (a_oe),
        .bus_b_addr (bus_b),
        .bus_b_oe   (b_oe),
        .frame_start(fs),
        .swap_state (sw)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // a two-state simulator resolves undriven lines to zero
    function automatic bit released(input logic [AW-1:0] v);
        return (v === {AW{1'bz}}) || (v === '0);
    endfunction

    // behavioural reference model
    int m_s1 = 0, m_s2 = 0, m_swap = 0, m_pre = 0, m_cnt = 0, m_fs = 0;
    int m_oaddr = 0, m_osel = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_swap = 0; m_pre = 0; m_cnt = 0;
            m_fs = 0; m_oaddr = 0; m_osel = 0;
        end else begin
            int fall;
            fall    = (m_s2 == 1 && m_s1 == 0) ? 1 : 0;
            m_oaddr = m_cnt;
            m_osel  = m_swap;
            m_fs    = fall;
            if (fall == 1) begin
                m_swap = 1 - m_swap;
                m_pre  = 0;
                m_cnt  = 0;
            end else if (m_pre == PRE - 1) begin
                m_pre = 0;
                m_cnt = (m_cnt == FLEN - 1) ? 0 : m_cnt + 1;
            end else begin
                m_pre++;
            end
            m_s2 = m_s1;
            m_s1 = vsync ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            if (m_osel == 0) begin
                check(bus_a === AW'(m_oaddr), "R7 bus A address", int'(bus_a), m_oaddr);
                check(a_oe === 1'b1, "R7 bus A enable", int'(a_oe), 1);
                check(b_oe === 1'b0 && released(bus_b), "R8 bus B released", int'(bus_b), 0);
            end else begin
                check(bus_b === AW'(m_oaddr), "R7 bus B address", int'(bus_b), m_oaddr);
                check(b_oe === 1'b1, "R7 bus B enable", int'(b_oe), 1);
                check(a_oe === 1'b0 && released(bus_a), "R8 bus A released", int'(bus_a), 0);
            end
            check(sw == m_swap[0], "R4 swap_state", int'(sw), m_swap);
            check(fs == m_fs[0], "R6 frame_start", int'(fs), m_fs);
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [AW-1:0] prev;
        int gap;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(a_oe == 1'b1 && bus_a == '0, "R1 bus A shown at 0", int'(bus_a), 0);
        check(b_oe == 1'b0, "R1 bus B released", int'(b_oe), 0);
        check(sw == 1'b0 && fs == 1'b0, "R1 swap and pulse clear", int'({sw, fs}), 0);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R2 spacing of address changes
        prev = bus_a;
        do @(negedge clk); while (bus_a == prev);
        prev = bus_a;
        gap = 0;
        do begin @(negedge clk); gap++; end while (bus_a == prev);
        check(gap == PRE, "R2 clocks between advances", gap, PRE);
        check(bus_a == prev + 1'b1, "R2 advance by one", int'(bus_a), int'(prev) + 1);

        // R3 wrap after the last position
        gap = 0;
        while (bus_a != AW'(FLEN - 1) && gap < 4000) begin @(negedge clk); gap++; end
        check(bus_a == AW'(FLEN - 1), "R3 last position reached", int'(bus_a), FLEN - 1);
        gap = 0;
        do begin @(negedge clk); gap++; end while (bus_a == AW'(FLEN - 1) && gap < 100);
        check(bus_a == '0, "R3 wrap to zero", int'(bus_a), 0);
        check(gap == PRE, "R3 wrap timing", gap, PRE);

        // R5 rising edge and steady high leave the selection alone
        vsync = 1'b1;
        repeat (60) @(negedge clk);
        check(sw == 1'b0, "R5 no swap on rise or level", int'(sw), 0);

        // R4 falling edge flips after two edges; R6 pulse and restart
        vsync = 1'b0;
        @(negedge clk);
        check(sw == 1'b0, "R4 not yet swapped", int'(sw), 0);
        @(negedge clk);
        check(sw == 1'b1, "R4 swapped on fall", int'(sw), 1);
        check(fs == 1'b1, "R6 frame_start with swap", int'(fs), 1);
        @(negedge clk);
        check(fs == 1'b0, "R6 pulse one cycle", int'(fs), 0);
        check(b_oe == 1'b1 && bus_b == '0, "R6 bus B restarts at 0", int'(bus_b), 0);
        check(a_oe == 1'b0 && released(bus_a), "R8 bus A floats", int'(bus_a), 0);

        repeat (300) @(negedge clk);
        check(sw == 1'b1, "R5 steady low keeps selection", int'(sw), 1);

        // second frame boundary, mid-scan restart
        vsync = 1'b1;
        repeat (40) @(negedge clk);
        vsync = 1'b0;
        repeat (3) @(negedge clk);
        check(sw == 1'b0 && a_oe == 1'b1, "R4 swap back to bus A", int'(sw), 0);

        // one-cycle high pulse still forms a falling edge
        repeat (100) @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        repeat (4) @(negedge clk);
        check(sw == 1'b1, "R4 short pulse swaps", int'(sw), 1);

        repeat (800) @(negedge clk);
        finish_run();
    end
endmodule